// File: doc/BRIEF.md
# Packed Single Denormal Control Unit

This block sits around a four-lane packed single-precision arithmetic core and handles denormal values at both ends of it. It holds a control/status register with a sticky exception flag group, an exception mask group, a rounding-control field, and two non-IEEE speed modes:

- **Zero-substitution mode** acts on source operands. It replaces each denormal source lane with a zero that keeps that lane's sign, before the core uses the lane.
- **Flush mode** acts on results. It turns each result lane that the core marks as tiny into a signed zero.

Source and result lanes pass through combinationally. Any flags raised in a cycle are OR-ed into the register at the next clock edge.

The register is written through a simple write strobe. Any write that tries to set a bit outside the writable-bit mask is refused. The register keeps its value, and a fault strobe pulses for one cycle. The arithmetic, the rounding and the trap handling belong to other blocks.

Top module: `pfp_denorm_ctl`

## Requirements
- R1: After reset the register reads 0x00001F80. The flags (bits 5:0) are 0. The zero-substitution bit (bit 6) is 0. The masks (bits 12:7) are 1. The flush bit (bit 15) is 0.
- R2: A source lane is denormal when its exponent field (bits 30:23) is zero and its fraction (bits 22:0) is non-zero. While bit 6 is set, every denormal lane on `src_out` is replaced in the same cycle by {sign,31'b0}. Zero, infinity and NaN lanes pass unchanged.
- R3: While bit 6 is set, a denormal source never sets the denormal flag (bit 1), and `de_req` stays low whatever the denormal mask (bit 8) holds.
- R4: While bit 6 is clear, `src_out` equals `src_in`. A valid denormal source sets bit 1 at the next edge. `de_req` is high in the same cycle only if bit 8 is 0.
- R5: While the flush bit (bit 15) and the underflow mask (bit 11) are both 1, each result lane with its `res_tiny` bit set leaves as {sign,31'b0}. A valid flush sets the underflow flag (bit 4) and the precision flag (bit 5) at the next edge.
- R6: While bit 11 is 0, the flush bit is ignored and `res_out` equals `res_in`. A valid tiny lane raises `uf_req` in the same cycle and sets bit 4 only, not bit 5.
- R7: While bit 15 is 0, `res_out` equals `res_in`, and tiny results set no flag.
- R8: A write that has a 1 in any bit the writable-bit mask clears leaves the register unchanged. `wr_fault` is then high for exactly the one cycle after the write. This includes bit 6 when the mask clears it.
- R9: A legal write loads the register at the next edge, and `wr_fault` stays low.
- R10: Flags are sticky and clear only by reset or a legal write. Flags raised in the same cycle as a legal write are OR-ed into the written value.
- R11: Each lane is decided on its own lane data and its own `res_tiny` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_data | input | 32 | Register write value |
| csr_rd_data | output | 32 | Current register value |
| wr_fault | output | 1 | One-cycle pulse after a refused write |
| src_valid | input | 1 | Source operand present |
| src_in | input | 128 | Four packed single source lanes |
| src_out | output | 128 | Source lanes after zero substitution |
| de_req | output | 1 | Unmasked denormal-operand request |
| res_valid | input | 1 | Result present |
| res_in | input | 128 | Four packed single result lanes |
| res_tiny | input | 4 | Per-lane tiny marks |
| res_out | output | 128 | Result lanes after flushing |
| uf_req | output | 1 | Unmasked underflow request |

## Verification
In a single cycle, a register write can coincide with a flag update from the source or result side. The bench provokes this by driving a legal write that turns on zero substitution while a denormal source is valid. Because the mode in force is still the old one, the denormal flag must appear OR-ed into the newly written value. A refused write can also meet a flag update. The bench checks that the register then keeps its old value plus only the new flags, and that the fault strobe rises in the following cycle.

// File: rtl/pfp_denorm_ctl.sv
module pfp_denorm_ctl #(
  parameter int LANES = 4,
  parameter int CSR_W = 32,
  parameter logic [CSR_W-1:0] WR_MASK = 32'h0000_FFFF,
  parameter logic [CSR_W-1:0] RST_VAL = 32'h0000_1F80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csr_wr_en,
  input  logic [CSR_W-1:0]      csr_wr_data,
  output logic [CSR_W-1:0]      csr_rd_data,
  output logic                  wr_fault,
  input  logic                  src_valid,
  input  logic [LANES*32-1:0]   src_in,
  output logic [LANES*32-1:0]   src_out,
  output logic                  de_req,
  input  logic                  res_valid,
  input  logic [LANES*32-1:0]   res_in,
  input  logic [LANES-1:0]      res_tiny,
  output logic [LANES*32-1:0]   res_out,
  output logic                  uf_req
);
  localparam int B_DE  = 1;
  localparam int B_UE  = 4;
  localparam int B_PE  = 5;
  localparam int B_DAZ = 6;
  localparam int B_DM  = 8;
  localparam int B_UM  = 11;
  localparam int B_FTZ = 15;

  logic [CSR_W-1:0] csr_q;
  logic [CSR_W-1:0] set_bits;
  logic [LANES-1:0] den_src, flush;

  wire zsub = csr_q[B_DAZ];
  wire ftz  = csr_q[B_FTZ];
  wire dm   = csr_q[B_DM];
  wire um   = csr_q[B_UM];

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      wire [31:0] s = src_in[i*32 +: 32];
      wire [31:0] r = res_in[i*32 +: 32];
      assign den_src[i] = (s[30:23] == 8'd0) && (s[22:0] != 23'd0);
      assign src_out[i*32 +: 32] = (zsub && den_src[i]) ? {s[31], 31'd0} : s;
      assign flush[i] = res_tiny[i] && ftz && um;
      assign res_out[i*32 +: 32] = flush[i] ? {r[31], 31'd0} : r;
    end
  endgenerate

  wire de_hit    = src_valid && |den_src && !zsub;
  wire flush_any = res_valid && |flush;
  wire uf_unm    = res_valid && |res_tiny && !um;
  wire illegal   = |(csr_wr_data & ~WR_MASK);

  assign de_req = de_hit && !dm;
  assign uf_req = uf_unm;
  assign csr_rd_data = csr_q;

  always_comb begin
    set_bits = '0;
    set_bits[B_DE] = de_hit;
    set_bits[B_UE] = flush_any || uf_unm;
    set_bits[B_PE] = flush_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q    <= RST_VAL;
      wr_fault <= 1'b0;
    end else begin
      wr_fault <= csr_wr_en && illegal;
      if (csr_wr_en && !illegal) csr_q <= csr_wr_data | set_bits;
      else                       csr_q <= csr_q | set_bits;
    end
  end

  // R8
  refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_en && illegal && !src_valid && !res_valid) |=> (csr_q == $past(csr_q)) && wr_fault);

  // R3
  zsub_no_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zsub |-> !de_req);

  // R10
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wr_en |=> ((csr_q[5:0] & $past(csr_q[5:0])) == $past(csr_q[5:0])));

  // R6
  unmasked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !um |-> (res_out == res_in));

  // R11
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_out[31] == src_in[31]) && (res_out[LANES*32-1] == res_in[LANES*32-1]));
endmodule

// File: tb/test_pfp_denorm_ctl.sv
module test_pfp_denorm_ctl;
  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic         wr_en = 0, sv = 0, rv = 0;
  logic [31:0]  wr_data = 0;
  logic [127:0] src = 0, res = 0;
  logic [3:0]   tiny = 0;
  logic [31:0]  csr;
  logic         flt, de, uf;
  logic [127:0] src_o, res_o;

  logic         w2_en = 0;
  logic [31:0]  w2_data = 0, csr2;
  logic         flt2, de2, uf2;
  logic [127:0] so2, ro2;

  pfp_denorm_ctl i_pfp_denorm_ctl (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(wr_en), .csr_wr_data(wr_data),
    .csr_rd_data(csr), .wr_fault(flt), .src_valid(sv), .src_in(src),
    .src_out(src_o), .de_req(de), .res_valid(rv), .res_in(res),
    .res_tiny(tiny), .res_out(res_o), .uf_req(uf));

  pfp_denorm_ctl #(.WR_MASK(32'h0000_FFBF)) i_pfp_denorm_ctl_nz (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(w2_en), .csr_wr_data(w2_data),
    .csr_rd_data(csr2), .wr_fault(flt2), .src_valid(1'b0), .src_in(128'd0),
    .src_out(so2), .de_req(de2), .res_valid(1'b0), .res_in(128'd0),
    .res_tiny(4'd0), .res_out(ro2), .uf_req(uf2));

  typedef struct {
    string tag;
    logic [127:0] src_e, res_e;
    logic de_e, uf_e, flt_e;
    logic [31:0] csr_e;
  } item_t;
  item_t q[$];

  int tests = 0, fails = 0;
  logic [31:0] m_csr = 32'h1F80;
  logic        m_flt = 0;

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic w, logic [31:0] wd, logic s_v, logic [127:0] s,
                      logic r_v, logic [127:0] r, logic [3:0] t, string tag);
    item_t it;
    logic [31:0] fl;
    logic anyden;
    @(negedge clk); #1;
    wr_en = w; wr_data = wd; sv = s_v; src = s; rv = r_v; res = r; tiny = t;
    it.tag = tag; it.csr_e = m_csr; it.flt_e = m_flt;
    anyden = 0; fl = 0;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] sl, rl;
      logic dn;
      sl = s[k*32 +: 32]; rl = r[k*32 +: 32];
      dn = (sl[30:23] == 0) && (sl[22:0] != 0);
      anyden |= dn;
      it.src_e[k*32 +: 32] = (m_csr[6] && dn) ? {sl[31], 31'd0} : sl;
      it.res_e[k*32 +: 32] = (t[k] && m_csr[15] && m_csr[11]) ? {rl[31], 31'd0} : rl;
    end
    it.de_e = s_v && anyden && !m_csr[6] && !m_csr[8];
    it.uf_e = r_v && (t != 0) && !m_csr[11];
    if (s_v && anyden && !m_csr[6]) fl[1] = 1;
    if (r_v && (t != 0) && !m_csr[11]) fl[4] = 1;
    if (r_v && (t != 0) && m_csr[11] && m_csr[15]) fl[5:4] = 2'b11;
    q.push_back(it);
    m_flt = w && (wd[31:16] != 0);
    if (w && wd[31:16] == 0) m_csr = wd | fl; else m_csr = m_csr | fl;
  endtask

  initial begin
    forever begin
      @(negedge clk); #9;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(it.tag, "src_out", src_o, it.src_e);
        chk(it.tag, "res_out", res_o, it.res_e);
        chk(it.tag, "de_req", {127'd0, de}, {127'd0, it.de_e});
        chk(it.tag, "uf_req", {127'd0, uf}, {127'd0, it.uf_e});
        chk(it.tag, "csr", {96'd0, csr}, {96'd0, it.csr_e});
        chk(it.tag, "wr_fault", {127'd0, flt}, {127'd0, it.flt_e});
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [127:0] SRC_A = {32'h0000_0000, 32'h7F80_0000, 32'h8040_0000, 32'h0000_0001};
  localparam logic [127:0] SRC_B = {32'h0000_0000, 32'h7FC0_0001, 32'h8000_0003, 32'h3F80_0000};
  localparam logic [127:0] RES_A = {32'h3F80_0000, 32'h0012_0000, 32'h0000_5678, 32'h8000_1234};
  localparam logic [127:0] RES_B = {32'h8000_0001, 32'h0000_0010, 32'h0000_0020, 32'h0000_0030};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 1, SRC_A, 0, 0, 0, "R4");
    step(1, 32'h1E80, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 1, SRC_A, 0, 0, 0, "R4");
    step(1, 32'h1EC0, 1, SRC_A, 0, 0, 0, "R10");
    step(0, 0, 1, SRC_A, 0, 0, 0, "R2");
    step(0, 0, 1, SRC_B, 0, 0, 0, "R3");
    step(1, 32'h9EC0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, RES_A, 4'b0101, "R5");
    step(0, 0, 0, 0, 1, RES_B, 4'b0010, "R11");
    step(1, 32'h0001_0000, 0, 0, 0, 0, 0, "R8");
    step(1, 32'h8000_0000, 0, 0, 1, RES_B, 4'b0001, "R8");
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 32'h96C0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, RES_B, 4'b1000, "R6");
    step(1, 32'h1EC0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, RES_B, 4'b1111, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    @(negedge clk); #1;
    w2_en = 1; w2_data = 32'h0000_1FC0;
    @(negedge clk); #1;
    w2_en = 0;
    #7;
    chk("R8", "fault_bit6", {127'd0, flt2}, {127'd0, 1'b1});
    chk("R8", "csr_bit6", {96'd0, csr2}, {96'd0, 32'h0000_1F80});
    @(negedge clk); #9;
    chk("R8", "fault_pulse_end", {127'd0, flt2}, 128'd0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule